// File: doc/BRIEF.md
# Predicated Tensor-Scalar Blend Engine

This block runs one already-checked select job over a lane-banked scratch memory. For every active lane it walks a three-dimensional address pattern over a source tensor and reads each element. It then writes one element to the matching position of a destination pattern. That element is either the source element or a scalar immediate. A 0/1 predicate picks between the two, and a reverse flag swaps which of the two is taken when the predicate is true. The predicate is supplied, never computed: it is either one inline value shared by all lanes or a per-lane 32-bit word fetched through a side port.

Elements are 8, 16 or 32 bits wide. They are copied bit-exact, with byte strobes so that only the element's own bytes change in memory. The job configuration must be held stable while `busy` is high. A job begins with a one-cycle `start`, and a one-cycle `done` marks its end.

Top module: `tsblend_engine`

## Requirements
- R1: With `reversePred`=0, each destination element is the source element when the predicate is true and the scalar when it is false.
- R2: With `reversePred`=1, each destination element is the scalar when the predicate is true and the source element when it is false.
- R3: With `predFromPtr`=0, the single value `predImm` applies to every lane, and a nonzero value counts as true.
- R4: With `predFromPtr`=1, each lane's predicate is the `fetchPred` word returned for that lane, and any nonzero 32-bit value counts as true. Each lane is fetched once: `fetchEn` is high for one cycle, the data returns the next cycle, and the lane's first read comes one cycle after that.
- R5: The scalar is `scalarImm`, or the lane's `fetchScalar` when `scalarFromPtr`=1. It is cut to the low 8, 16 or 32 bits by element width and written to every element that selects it.
- R6: `widthSel` encodes the element width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. Data is little-endian in the low bytes of `rdData`/`wrData`. `wrStrb` enables only bytes 0..width-1, so no other memory byte changes.
- R7: The element offset is i0*step[0] + i1*step[1] + i2*step[2], with signed 16-bit steps. The loop over i0 (count[0]) is innermost and the loop over i2 is outermost. The byte address is the base plus the offset times the element byte size, taken modulo 2^ADDR_W.
- R8: Exactly one write follows each read, for lanes 0 to `laneCount`-1 only. Memory in every other lane is left untouched.
- R9: `done` is high for exactly one cycle, in the cycle after the last write. `busy` is low in that cycle and in idle, where no memory or fetch strobe is active.
- R10: A `start` that arrives while `busy` is high has no effect on the running job.
- R11: Each element takes two cycles (read, then write), and each lane adds two cycles when either pointer mode is on. `done` is therefore high after edge L*(2E+2p) counted from the start edge, where E is the element count per lane and p is 1 in pointer mode and 0 otherwise.
- R12: After reset, `busy`, `done`, `rdEn`, `wrEn` and `fetchEn` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job (sampled when idle) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| widthSel | input | 2 | Element width code |
| reversePred | input | 1 | Swap the arm taken on true |
| predFromPtr | input | 1 | Predicate fetched per lane |
| scalarFromPtr | input | 1 | Scalar fetched per lane |
| predImm | input | 32 | Inline predicate |
| scalarImm | input | 32 | Inline scalar |
| laneCount | input | LANE_W+1 | Active lanes, 1..LANES |
| elemCount | input | 3*CNT_W | Per-dimension counts, each at least 1 |
| srcBase | input | ADDR_W | Source start byte address |
| srcStep | input | 3*STEP_W | Signed source element strides |
| dstBase | input | ADDR_W | Destination start byte address |
| dstStep | input | 3*STEP_W | Signed destination element strides |
| rdEn | output | 1 | Memory read strobe |
| rdLane | output | LANE_W | Read bank |
| rdAddr | output | ADDR_W | Read byte address |
| rdData | input | 32 | Read data, one cycle after rdEn |
| wrEn | output | 1 | Memory write strobe |
| wrLane | output | LANE_W | Write bank |
| wrAddr | output | ADDR_W | Write byte address |
| wrData | output | 32 | Write data |
| wrStrb | output | 4 | Byte enables |
| fetchEn | output | 1 | Per-lane pointer fetch strobe |
| fetchLane | output | LANE_W | Lane being fetched |
| fetchPred | input | 32 | Fetched predicate, one cycle after fetchEn |
| fetchScalar | input | 32 | Fetched scalar, one cycle after fetchEn |

## Verification
Memory reads return data one cycle after `rdEn`. The write that uses that data comes in the next cycle, and `done` rises on the edge after the last write. The bench counts negative edges from the start edge and requires `done` at exactly L*(2E+2p). It then requires `done` low one edge later. Memory contents are compared only after `done`, against an image the bench builds from the requirements, and the compare covers one lane past the active range. Write and `done` pulses are counted from the bus, so a stray second job shows up as an excess count.

// File: rtl/tsblend_pkg.sv
package tsblend_pkg;
  typedef enum logic [1:0] {
    ELEM_B8  = 2'd0,
    ELEM_B16 = 2'd1,
    ELEM_B32 = 2'd2
  } elem_w_e;

  // strobes from control to datapath, one per control state that acts
  typedef struct packed {
    logic fetch;
    logic latchImm;
    logic rd;
    logic wr;
  } strobe_t;
endpackage

// File: rtl/tsblend_ctrl.sv
module tsblend_ctrl
  import tsblend_pkg::*;
#(
  parameter int LANES = 128,
  parameter int CNT_W = 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    usePtr,
  input  logic [LANE_W:0]         laneCount,
  input  logic [2:0][CNT_W-1:0]   elemCount,
  output strobe_t                 stb,
  output logic [LANE_W-1:0]       lane,
  output logic [2:0][CNT_W-1:0]   idx,
  output logic                    busy,
  output logic                    done
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_READ, S_WRITE} state_e;
  state_e state;

  logic [2:0] lastIdx;
  logic       lastLane;

  for (genvar d = 0; d < 3; d++) begin : gLast
    assign lastIdx[d] = (idx[d] == elemCount[d] - 1'b1);
  end
  assign lastLane = ({1'b0, lane} == laneCount - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      lane  <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          lane  <= '0;
          idx   <= '0;
          state <= usePtr ? S_FETCH : S_READ;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD:  state <= S_READ;
        S_READ:  state <= S_WRITE;
        S_WRITE: begin
          state <= S_READ;
          if (!lastIdx[0]) idx[0] <= idx[0] + 1'b1;
          else begin
            idx[0] <= '0;
            if (!lastIdx[1]) idx[1] <= idx[1] + 1'b1;
            else begin
              idx[1] <= '0;
              if (!lastIdx[2]) idx[2] <= idx[2] + 1'b1;
              else begin
                idx[2] <= '0;
                if (lastLane) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
                end else begin
                  lane  <= lane + 1'b1;
                  state <= usePtr ? S_FETCH : S_READ;
                end
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign stb.fetch    = (state == S_FETCH);
  assign stb.latchImm = (state == S_LOAD);
  assign stb.rd       = (state == S_READ);
  assign stb.wr       = (state == S_WRITE);
  assign busy         = (state != S_IDLE);
endmodule

// File: rtl/tsblend_dp.sv
module tsblend_dp
  import tsblend_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 8,
  localparam int OFF_W = STEP_W + CNT_W + 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [1:0]             widthSel,
  input  logic                   reversePred,
  input  logic                   predFromPtr,
  input  logic                   scalarFromPtr,
  input  logic [31:0]            predImm,
  input  logic [31:0]            scalarImm,
  input  logic [ADDR_W-1:0]      srcBase,
  input  logic [2:0][STEP_W-1:0] srcStep,
  input  logic [ADDR_W-1:0]      dstBase,
  input  logic [2:0][STEP_W-1:0] dstStep,
  input  logic [2:0][CNT_W-1:0]  idx,
  input  logic [31:0]            fetchPred,
  input  logic [31:0]            fetchScalar,
  input  logic [31:0]            rdData,
  output logic                   rdEn,
  output logic                   wrEn,
  output logic                   fetchEn,
  output logic [ADDR_W-1:0]      rdAddr,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [31:0]            wrData,
  output logic [3:0]             wrStrb
);
  logic [31:0] predReg, scalarReg;
  logic [31:0] widthMask, scalarSel;
  logic [3:0]  strbVal;
  logic [1:0]  byteShift;
  logic        predTrue;

  function automatic logic [ADDR_W-1:0] patAddr(
    input logic [ADDR_W-1:0]      base,
    input logic [2:0][STEP_W-1:0] st,
    input logic [2:0][CNT_W-1:0]  ix,
    input logic [1:0]             sh
  );
    logic signed [OFF_W-1:0] acc;
    acc = '0;
    for (int d = 0; d < 3; d++)
      acc = acc + OFF_W'($signed({1'b0, ix[d]})) * OFF_W'($signed(st[d]));
    acc = acc <<< sh;
    return base + acc[ADDR_W-1:0];
  endfunction

  always_comb begin
    unique case (elem_w_e'(widthSel))
      ELEM_B8:  begin widthMask = 32'h0000_00FF; strbVal = 4'b0001; byteShift = 2'd0; end
      ELEM_B16: begin widthMask = 32'h0000_FFFF; strbVal = 4'b0011; byteShift = 2'd1; end
      default:  begin widthMask = 32'hFFFF_FFFF; strbVal = 4'b1111; byteShift = 2'd2; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predReg   <= '0;
      scalarReg <= '0;
    end else if (stb.latchImm) begin
      predReg   <= fetchPred;
      scalarReg <= fetchScalar;
    end
  end

  assign predTrue  = predFromPtr ? (predReg != '0) : (predImm != '0);
  assign scalarSel = scalarFromPtr ? scalarReg : scalarImm;

  assign rdAddr  = patAddr(srcBase, srcStep, idx, byteShift);
  assign wrAddr  = patAddr(dstBase, dstStep, idx, byteShift);
  assign wrData  = ((predTrue ^ reversePred) ? rdData : scalarSel) & widthMask;
  assign wrStrb  = stb.wr ? strbVal : 4'b0000;
  assign rdEn    = stb.rd;
  assign wrEn    = stb.wr;
  assign fetchEn = stb.fetch;
endmodule

// File: rtl/tsblend_engine.sv
module tsblend_engine
  import tsblend_pkg::*;
#(
  parameter int LANES  = 128,
  parameter int ADDR_W = 16,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  input  logic [1:0]             widthSel,
  input  logic                   reversePred,
  input  logic                   predFromPtr,
  input  logic                   scalarFromPtr,
  input  logic [31:0]            predImm,
  input  logic [31:0]            scalarImm,
  input  logic [LANE_W:0]        laneCount,
  input  logic [2:0][CNT_W-1:0]  elemCount,
  input  logic [ADDR_W-1:0]      srcBase,
  input  logic [2:0][STEP_W-1:0] srcStep,
  input  logic [ADDR_W-1:0]      dstBase,
  input  logic [2:0][STEP_W-1:0] dstStep,
  output logic                   rdEn,
  output logic [LANE_W-1:0]      rdLane,
  output logic [ADDR_W-1:0]      rdAddr,
  input  logic [31:0]            rdData,
  output logic                   wrEn,
  output logic [LANE_W-1:0]      wrLane,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [31:0]            wrData,
  output logic [3:0]             wrStrb,
  output logic                   fetchEn,
  output logic [LANE_W-1:0]      fetchLane,
  input  logic [31:0]            fetchPred,
  input  logic [31:0]            fetchScalar
);
  strobe_t                stb;
  logic [LANE_W-1:0]      lane;
  logic [2:0][CNT_W-1:0]  idx;

  tsblend_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .usePtr(predFromPtr | scalarFromPtr),
    .laneCount(laneCount), .elemCount(elemCount),
    .stb(stb), .lane(lane), .idx(idx), .busy(busy), .done(done)
  );

  tsblend_dp #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .widthSel(widthSel),
    .reversePred(reversePred), .predFromPtr(predFromPtr),
    .scalarFromPtr(scalarFromPtr), .predImm(predImm), .scalarImm(scalarImm),
    .srcBase(srcBase), .srcStep(srcStep), .dstBase(dstBase), .dstStep(dstStep),
    .idx(idx), .fetchPred(fetchPred), .fetchScalar(fetchScalar), .rdData(rdData),
    .rdEn(rdEn), .wrEn(wrEn), .fetchEn(fetchEn),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData), .wrStrb(wrStrb)
  );

  assign rdLane    = lane;
  assign wrLane    = lane;
  assign fetchLane = lane;
endmodule

// File: rtl/tsblend_checker.sv
module tsblend_checker #(
  parameter int LANES = 128,
  localparam int LANE_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              rdEn,
  input logic              wrEn,
  input logic              fetchEn,
  input logic [LANE_W-1:0] wrLane,
  input logic [LANE_W:0]   laneCount
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdEn, wrEn, fetchEn}));                                // R11
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(rdEn));                                           // R8
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> wrEn);                                                  // R8
  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ({1'b0, wrLane} < laneCount));                          // R8
  AST_FETCH_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn |=> ##1 rdEn);                                           // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                 // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(wrEn) && !busy));                                // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(rdEn || wrEn || fetchEn));                           // R9
endmodule

bind tsblend_engine tsblend_checker #(.LANES(LANES)) uChk (.*);

// File: tb/tsblend_engine_test.sv
`timescale 1ns/1ps
module tsblend_engine_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0;
  logic busy, done;
  logic [1:0] widthSel = '0;
  logic reversePred = 1'b0, predFromPtr = 1'b0, scalarFromPtr = 1'b0;
  logic [31:0] predImm = '0, scalarImm = '0;
  logic [7:0] laneCount = 8'd1;
  logic [2:0][7:0] elemCount = '0;
  logic [15:0] srcBase = '0, dstBase = '0;
  logic [2:0][15:0] srcStep = '0, dstStep = '0;
  logic rdEn, wrEn, fetchEn;
  logic [6:0] rdLane, wrLane, fetchLane;
  logic [15:0] rdAddr, wrAddr;
  logic [31:0] rdData = '0, wrData, fetchPred = '0, fetchScalar = '0;
  logic [3:0] wrStrb;

  tsblend_engine uut (.*);

  // bench memory, lanes 0..7 modelled
  logic [7:0] mem [0:7][0:255];
  logic [7:0] expv [0:7][0:255];
  logic [31:0] predTab [0:7];
  logic [31:0] scalTab [0:7];
  logic fillNow = 1'b0;
  int wrCount = 0, doneCount = 0;
  int nChk = 0, nFail = 0;

  int cfgW, cfgRev, cfgPP, cfgSP, cfgL;
  int cfgPred, cfgScal;
  int cnt [3];
  int sStep [3];
  int dStep [3];
  int sBase, dBase;

  function automatic logic [7:0] initVal(int l, int a);
    return 8'(l * 37 + a * 5 + 3);
  endfunction

  always @(posedge clk) begin
    if (fillNow) begin
      for (int l = 0; l < 8; l++)
        for (int a = 0; a < 256; a++) mem[l][a] <= initVal(l, a);
    end else begin
      if (rdEn)
        rdData <= {mem[rdLane[2:0]][8'(rdAddr + 3)], mem[rdLane[2:0]][8'(rdAddr + 2)],
                   mem[rdLane[2:0]][8'(rdAddr + 1)], mem[rdLane[2:0]][rdAddr[7:0]]};
      if (wrEn)
        for (int b = 0; b < 4; b++)
          if (wrStrb[b]) mem[wrLane[2:0]][8'(wrAddr + b)] <= wrData[8*b +: 8];
      if (fetchEn) begin
        fetchPred   <= predTab[fetchLane[2:0]];
        fetchScalar <= scalTab[fetchLane[2:0]];
      end
    end
    if (wrEn) wrCount <= wrCount + 1;
    if (done) doneCount <= doneCount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic applyCfg();
    widthSel = 2'(cfgW); reversePred = cfgRev[0];
    predFromPtr = cfgPP[0]; scalarFromPtr = cfgSP[0];
    predImm = 32'(cfgPred); scalarImm = 32'(cfgScal);
    laneCount = 8'(cfgL);
    srcBase = 16'(sBase); dstBase = 16'(dBase);
    for (int d = 0; d < 3; d++) begin
      elemCount[d] = 8'(cnt[d]);
      srcStep[d] = 16'(sStep[d]);
      dstStep[d] = 16'(dStep[d]);
    end
  endtask

  // expected image from the requirements (R1, R2, R3, R4, R5, R6, R7, R8)
  task automatic buildExp();
    int nb;
    nb = (cfgW == 0) ? 1 : (cfgW == 1) ? 2 : 4;
    for (int l = 0; l < 8; l++)
      for (int a = 0; a < 256; a++) expv[l][a] = initVal(l, a);
    for (int l = 0; l < cfgL; l++) begin
      bit p;
      logic [31:0] sc;
      p  = cfgPP ? (predTab[l] != 0) : (cfgPred != 0);
      sc = cfgSP ? scalTab[l] : 32'(cfgScal);
      for (int i2 = 0; i2 < cnt[2]; i2++)
        for (int i1 = 0; i1 < cnt[1]; i1++)
          for (int i0 = 0; i0 < cnt[0]; i0++) begin
            int sa, da;
            sa = sBase + (i0 * sStep[0] + i1 * sStep[1] + i2 * sStep[2]) * nb;
            da = dBase + (i0 * dStep[0] + i1 * dStep[1] + i2 * dStep[2]) * nb;
            for (int b = 0; b < nb; b++)
              expv[l][8'(da + b)] = (p ^ cfgRev[0]) ? initVal(l, 8'(sa + b)) : sc[8*b +: 8];
          end
    end
  endtask

  task automatic runJob(input string tag, input bit midStart);
    int cyc, e, expCyc, w0, d0;
    e = cnt[0] * cnt[1] * cnt[2];
    expCyc = cfgL * (2 * e + ((cfgPP || cfgSP) ? 2 : 0));
    applyCfg();
    @(negedge clk) fillNow = 1'b1;
    @(negedge clk) fillNow = 1'b0;
    buildExp();
    w0 = wrCount; d0 = doneCount;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      start = midStart && (cyc == 3);
      if (done) break;
      if (cyc > 20000) begin
        check(0, "R9", {tag, " done never seen"}, cyc, expCyc);
        break;
      end
    end
    start = 1'b0;
    check(cyc == expCyc, "R11", {tag, " cycles to done"}, cyc, expCyc);
    check(!busy, "R9", {tag, " busy low with done"}, busy, 0);
    @(negedge clk);
    check(!done, "R9", {tag, " done one cycle"}, done, 0);
    check(doneCount - d0 == 1, midStart ? "R10" : "R9", {tag, " done pulses"}, doneCount - d0, 1);
    check(wrCount - w0 == e * cfgL, midStart ? "R10" : "R8", {tag, " write count"},
          wrCount - w0, e * cfgL);
    for (int l = 0; l <= cfgL && l < 8; l++) begin
      int bad;
      bad = -1;
      for (int a = 0; a < 256; a++)
        if (bad < 0 && mem[l][a] !== expv[l][a]) bad = a;
      if (bad >= 0)
        check(0, (l == cfgL) ? "R8" : "R1/R2 data", $sformatf("%s lane %0d byte %0h", tag, l, bad),
              mem[l][bad], expv[l][bad]);
      else
        check(1, "R8", tag, 0, 0);
    end
  endtask

  task automatic setPat(int c0, int c1, int c2, int s0, int s1, int s2,
                        int t0, int t1, int t2, int sb, int db);
    cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
    sStep[0] = s0; sStep[1] = s1; sStep[2] = s2;
    dStep[0] = t0; dStep[1] = t1; dStep[2] = t2;
    sBase = sb; dBase = db;
  endtask

  task automatic tReset();
    check(!busy && !done, "R12", "busy/done after reset", {busy, done}, 0);
    check(!rdEn && !wrEn && !fetchEn, "R12", "strobes after reset", {rdEn, wrEn, fetchEn}, 0);
  endtask

  task automatic tCopy32();   // R1 R3 R6 R7: predicate 1, 32-bit tensor copy
    cfgW = 2; cfgRev = 0; cfgPP = 0; cfgSP = 0; cfgL = 2; cfgPred = 1; cfgScal = 32'h5555AAAA;
    setPat(4, 2, 1, 1, 4, 0, 1, 4, 0, 16'h0010, 16'h0080);
    runJob("copy32", 0);
  endtask

  task automatic tScalar16(); // R1 R3 R5 R6: predicate 0 gives low 16 bits of scalar
    cfgW = 1; cfgRev = 0; cfgPP = 0; cfgSP = 0; cfgL = 3; cfgPred = 0; cfgScal = 32'hABCD1234;
    setPat(2, 2, 2, 1, 2, 4, 1, 2, 4, 16'h0000, 16'h0060);
    runJob("scalar16", 0);
  endtask

  task automatic tRev8();     // R2 R5 R6: reverse flag at 1, both predicate values
    cfgW = 0; cfgRev = 1; cfgPP = 0; cfgSP = 0; cfgL = 2; cfgPred = 1; cfgScal = 32'h123456C3;
    setPat(5, 1, 1, 1, 0, 0, 2, 0, 0, 16'h0020, 16'h0070);
    runJob("rev8 pred1", 0);
    cfgPred = 0;
    runJob("rev8 pred0", 0);
  endtask

  task automatic tPointer();  // R4 R5: per-lane predicate and scalar, nonzero is true
    predTab[0] = 32'h0;        predTab[1] = 32'h100;
    predTab[2] = 32'h80000000; predTab[3] = 32'h0;
    for (int l = 0; l < 8; l++) scalTab[l] = 32'hC0DE0000 + 32'(l * 17);
    cfgW = 2; cfgRev = 0; cfgPP = 1; cfgSP = 1; cfgL = 4; cfgPred = 1; cfgScal = 32'hFFFFFFFF;
    setPat(3, 1, 1, 1, 0, 0, 1, 0, 0, 16'h0030, 16'h00C0);
    runJob("pointer both", 0);
    cfgSP = 0; cfgRev = 1; cfgScal = 32'h0BADF00D;  // pointer predicate, inline scalar
    runJob("pointer pred", 0);
  endtask

  task automatic tNegStride(); // R7: signed strides over all three dimensions
    cfgW = 1; cfgRev = 0; cfgPP = 0; cfgSP = 0; cfgL = 1; cfgPred = 7; cfgScal = 0;
    setPat(3, 2, 2, -1, -8, 16, 1, 3, 6, 16'h0040, 16'h00A0);
    runJob("negstride", 0);
  endtask

  task automatic tStartBusy(); // R10: start pulse mid-job ignored
    cfgW = 2; cfgRev = 0; cfgPP = 0; cfgSP = 0; cfgL = 2; cfgPred = 1; cfgScal = 0;
    setPat(4, 2, 1, 1, 4, 0, 1, 4, 0, 16'h0010, 16'h0080);
    runJob("start while busy", 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCopy32();
    tScalar16();
    tRev8();
    tPointer();
    tNegStride();
    tStartBusy();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule